// File: doc/BRIEF.md
# Serial Lane Bring-Up Sequencer

This block takes one multi-rate serial lane from reset to a state where data can flow. A one-cycle start request captures the chosen protocol (four-port multiplexed SGMII or plain SGMII), the line speed (1G or 2.5G), a two-bit reference-clock strap and the polarity and loopback options. From these it works out the PLL multiplier, the reference halving bit and the transmit and receive rate codes. It then drives the lane's control pins through a fixed enable order with millisecond-scale pauses and samples one lane status bit after each major stage.

When every status check passes, the block raises both data enables together with a `done` level. The first failed check stops the sequence and leaves a three-bit code on `err_o` until the next start. While `done` is high, a change of the protocol or speed inputs starts the whole sequence again. One cycle counter times all the pauses, and the `MS_CYCLES` parameter sets how many clock cycles make one millisecond.

Top module: `lane_bringup_seq`

## Requirements
- R1: After reset, `tx_rst_o`, `rx_rst_o` and `phy_rst_o` are 1, and every enable, `done_o`, `busy_o`, `mult_o` and `err_o` are 0.
- R2: The reference counts as 125 MHz when `ref_strap_i` is 1 or 2, and as the other reference when it is 0 or 3. `ref_half_o` is 1 exactly when the reference is 125 MHz.
- R3: With `mode_sgmii_i`=0 (multiplexed mode), `lane_10b_o`=0 and both rate codes are 0. `mult_o` is 40 with a 125 MHz reference and 100 otherwise.
- R4: With `mode_sgmii_i`=1, `lane_10b_o`=1. With `speed_2g5_i`=1 both rate codes are 1 and `mult_o` is 50 or 125. With `speed_2g5_i`=0 both rate codes are 2 and `mult_o` is 40 or 100. The first value of each pair applies with a 125 MHz reference.
- R5: Call the clock edge that samples a start edge 0. At edge 0 the block applies the lane select, rate codes, inverts and loopback and releases the TX and RX resets. At edge 1 it writes `mult_o` and `ref_half_o`, at edge 2 it holds `rx_term_o` at 0, and at edge 3 it sets `ssp_en_o`.
- R6: `phy_rst_o` falls MS cycles after `ssp_en_o` rises. `pll_en_o` rises MS cycles after that, and `tx_cm_en_o` rises 7*MS cycles after `pll_en_o`, but only if `st_pll_i` is 1 at that point.
- R7: `rxpll_en_o` and `tx_en_o` rise together MS cycles after `tx_cm_en_o`, but only if `st_cm_i` is 1 at that point.
- R8: A failed check sets `err_o` and stops the sequence. The codes are 1 for the PLL check, 2 for the common-mode check, 3 for the RX PLL check and 4 for the TX check. The RX PLL check is made before the TX check.
- R9: MS cycles after the RX PLL and TX enables rise, if both `st_rxpll_i` and `st_tx_i` are 1, `tx_data_en_o`, `rx_data_en_o` and `done_o` all rise in the same cycle. `done_o` then stays high.
- R10: A nonzero `err_o` holds until the next start, and the cycle after that start it reads 0.
- R11: A start pulse that arrives while `busy_o` is high has no effect on the timing or the outcome of the running sequence.
- R12: While `done_o` is high, a change on `mode_sgmii_i` or `speed_2g5_i` drops `done_o` on the next cycle and reruns the full sequence with the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| mode_sgmii_i | input | 1 | 0 = multiplexed four-port mode, 1 = SGMII |
| speed_2g5_i | input | 1 | 0 = 1G, 1 = 2.5G |
| ref_strap_i | input | 2 | Reference clock strap field |
| tx_inv_i | input | 1 | Requested TX polarity inversion |
| rx_inv_i | input | 1 | Requested RX polarity inversion |
| loopbk_i | input | 1 | Requested TX-to-RX loopback |
| st_pll_i | input | 1 | Lane PLL state status |
| st_cm_i | input | 1 | TX common-mode state status |
| st_rxpll_i | input | 1 | RX PLL state status |
| st_tx_i | input | 1 | TX operational status |
| lane_10b_o | output | 1 | 10-bit lane select |
| tx_rate_o | output | 2 | TX rate code |
| rx_rate_o | output | 2 | RX rate code |
| tx_inv_o | output | 1 | TX invert |
| rx_inv_o | output | 1 | RX invert |
| loopbk_o | output | 1 | Lane loopback enable |
| tx_rst_o | output | 1 | TX reset |
| rx_rst_o | output | 1 | RX reset |
| mult_o | output | 7 | PLL multiplier |
| ref_half_o | output | 1 | Reference halving |
| rx_term_o | output | 1 | RX termination enable |
| ssp_en_o | output | 1 | Reference SSP enable |
| phy_rst_o | output | 1 | Lane PHY reset |
| pll_en_o | output | 1 | PLL enable |
| tx_cm_en_o | output | 1 | TX common-mode enable |
| rxpll_en_o | output | 1 | RX PLL enable |
| tx_en_o | output | 1 | TX enable |
| tx_data_en_o | output | 1 | TX data enable |
| rx_data_en_o | output | 1 | RX data enable |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Lane ready level |
| err_o | output | 3 | Failure code, 0 = none |

## Verification
The hardest case to reach is a failure in the last check when both final status bits are low, because that is the only case where the RX-before-TX priority shows in the code. The bench holds the lane status inputs at chosen levels for the whole run, so each failure point is reached on purpose: it clears only the PLL bit, only the common-mode bit, both RX PLL and TX bits, and then only the TX bit. A second start is injected in the middle of a run, and the speed input is flipped while the lane is ready. Both cases are checked against cycle counts derived from MS.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;

    localparam int MULT_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PLLCFG, ST_TERM, ST_SSP, ST_W_SSP, ST_W_PHY,
        ST_W_PLL, ST_W_CM, ST_W_RXTX, ST_DONE, ST_ERR
    } seq_state_e;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_PLL   = 3'd1,
        ERR_CM    = 3'd2,
        ERR_RXPLL = 3'd3,
        ERR_TX    = 3'd4
    } seq_err_e;

    typedef struct packed {
        logic              lane10b;
        logic [1:0]        tx_rate;
        logic [1:0]        rx_rate;
        logic [MULT_W-1:0] mult;
        logic              ref_half;
    } lane_cfg_t;

    typedef struct packed {
        seq_state_e        state;
        logic              lane10b;
        logic [1:0]        tx_rate;
        logic [1:0]        rx_rate;
        logic              tx_inv;
        logic              rx_inv;
        logic              loopbk;
        logic              tx_rst;
        logic              rx_rst;
        logic [MULT_W-1:0] mult;
        logic              ref_half;
        logic [MULT_W-1:0] mult_pend;
        logic              half_pend;
        logic              rx_term;
        logic              ssp;
        logic              phy_rst;
        logic              pll_en;
        logic              cm_en;
        logic              rxpll_en;
        logic              tx_en;
        logic              txd_en;
        logic              rxd_en;
        logic              done;
        seq_err_e          err;
        logic              mode_q;
        logic              speed_q;
    } seq_regs_t;

endpackage

// File: rtl/lane_rate_calc.sv
module lane_rate_calc
    import lane_seq_pkg::*;
(
    input  logic       mode_sgmii_i,
    input  logic       speed_2g5_i,
    input  logic [1:0] ref_strap_i,
    output lane_cfg_t  cfg_o
);
    logic ref125;

    always_comb begin
        ref125 = (ref_strap_i == 2'd1) || (ref_strap_i == 2'd2);
        cfg_o          = '0;
        cfg_o.ref_half = ref125;
        if (!mode_sgmii_i) begin
            cfg_o.lane10b = 1'b0;
            cfg_o.tx_rate = 2'd0;
            cfg_o.rx_rate = 2'd0;
            cfg_o.mult    = ref125 ? MULT_W'(40) : MULT_W'(100);
        end else begin
            cfg_o.lane10b = 1'b1;
            cfg_o.tx_rate = speed_2g5_i ? 2'd1 : 2'd2;
            cfg_o.rx_rate = speed_2g5_i ? 2'd1 : 2'd2;
            if (speed_2g5_i) cfg_o.mult = ref125 ? MULT_W'(50) : MULT_W'(125);
            else             cfg_o.mult = ref125 ? MULT_W'(40) : MULT_W'(100);
        end
    end
endmodule

// File: rtl/lane_wait_timer.sv
module lane_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = load_val_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/lane_bringup_seq.sv
module lane_bringup_seq
    import lane_seq_pkg::*;
#(
    parameter int MS_CYCLES    = 125000,
    parameter int STEP_WAIT_MS = 1,
    parameter int PLL_WAIT_MS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_sgmii_i,
    input  logic              speed_2g5_i,
    input  logic [1:0]        ref_strap_i,
    input  logic              tx_inv_i,
    input  logic              rx_inv_i,
    input  logic              loopbk_i,
    input  logic              st_pll_i,
    input  logic              st_cm_i,
    input  logic              st_rxpll_i,
    input  logic              st_tx_i,
    output logic              lane_10b_o,
    output logic [1:0]        tx_rate_o,
    output logic [1:0]        rx_rate_o,
    output logic              tx_inv_o,
    output logic              rx_inv_o,
    output logic              loopbk_o,
    output logic              tx_rst_o,
    output logic              rx_rst_o,
    output logic [MULT_W-1:0] mult_o,
    output logic              ref_half_o,
    output logic              rx_term_o,
    output logic              ssp_en_o,
    output logic              phy_rst_o,
    output logic              pll_en_o,
    output logic              tx_cm_en_o,
    output logic              rxpll_en_o,
    output logic              tx_en_o,
    output logic              tx_data_en_o,
    output logic              rx_data_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [2:0]        err_o
);
    localparam int STEP_CYC = STEP_WAIT_MS * MS_CYCLES;
    localparam int LONG_CYC = PLL_WAIT_MS * MS_CYCLES;
    localparam int MAX_CYC  = (LONG_CYC > STEP_CYC) ? LONG_CYC : STEP_CYC;
    localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] WAIT_STEP = CNT_W'(STEP_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LONG = CNT_W'(LONG_CYC - 1);

    seq_regs_t        d, q;
    lane_cfg_t        calc;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             idle_like, cfg_moved;

    function automatic seq_regs_t reset_regs();
        seq_regs_t r;
        r         = '0;
        r.state   = ST_IDLE;
        r.err     = ERR_NONE;
        r.tx_rst  = 1'b1;
        r.rx_rst  = 1'b1;
        r.phy_rst = 1'b1;
        return r;
    endfunction

    lane_rate_calc i_calc (
        .mode_sgmii_i (mode_sgmii_i),
        .speed_2g5_i  (speed_2g5_i),
        .ref_strap_i  (ref_strap_i),
        .cfg_o        (calc)
    );

    lane_wait_timer #(.CNT_W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        d         = q;
        tmr_load  = 1'b0;
        tmr_val   = WAIT_STEP;
        idle_like = (q.state == ST_IDLE) || (q.state == ST_DONE) || (q.state == ST_ERR);
        cfg_moved = (q.state == ST_DONE) &&
                    ((mode_sgmii_i != q.mode_q) || (speed_2g5_i != q.speed_q));
        if ((idle_like && start_i) || cfg_moved) begin
            d           = reset_regs();
            d.state     = ST_PLLCFG;
            d.lane10b   = calc.lane10b;
            d.tx_rate   = calc.tx_rate;
            d.rx_rate   = calc.rx_rate;
            d.tx_inv    = tx_inv_i;
            d.rx_inv    = rx_inv_i;
            d.loopbk    = loopbk_i;
            d.tx_rst    = 1'b0;
            d.rx_rst    = 1'b0;
            d.mult_pend = calc.mult;
            d.half_pend = calc.ref_half;
            d.mode_q    = mode_sgmii_i;
            d.speed_q   = speed_2g5_i;
        end else begin
            case (q.state)
                ST_PLLCFG: begin
                    d.mult     = q.mult_pend;
                    d.ref_half = q.half_pend;
                    d.state    = ST_TERM;
                end
                ST_TERM: begin
                    d.rx_term = 1'b0;
                    d.state   = ST_SSP;
                end
                ST_SSP: begin
                    d.ssp    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = WAIT_STEP;
                    d.state  = ST_W_SSP;
                end
                ST_W_SSP: if (tmr_expired) begin
                    d.phy_rst = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = WAIT_STEP;
                    d.state   = ST_W_PHY;
                end
                ST_W_PHY: if (tmr_expired) begin
                    d.pll_en = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = WAIT_LONG;
                    d.state  = ST_W_PLL;
                end
                ST_W_PLL: if (tmr_expired) begin
                    if (st_pll_i) begin
                        d.cm_en  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = WAIT_STEP;
                        d.state  = ST_W_CM;
                    end else begin
                        d.err   = ERR_PLL;
                        d.state = ST_ERR;
                    end
                end
                ST_W_CM: if (tmr_expired) begin
                    if (st_cm_i) begin
                        d.rxpll_en = 1'b1;
                        d.tx_en    = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = WAIT_STEP;
                        d.state    = ST_W_RXTX;
                    end else begin
                        d.err   = ERR_CM;
                        d.state = ST_ERR;
                    end
                end
                ST_W_RXTX: if (tmr_expired) begin
                    if (!st_rxpll_i) begin
                        d.err   = ERR_RXPLL;
                        d.state = ST_ERR;
                    end else if (!st_tx_i) begin
                        d.err   = ERR_TX;
                        d.state = ST_ERR;
                    end else begin
                        d.txd_en = 1'b1;
                        d.rxd_en = 1'b1;
                        d.done   = 1'b1;
                        d.state  = ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_regs();
        else        q <= d;
    end

    assign lane_10b_o   = q.lane10b;
    assign tx_rate_o    = q.tx_rate;
    assign rx_rate_o    = q.rx_rate;
    assign tx_inv_o     = q.tx_inv;
    assign rx_inv_o     = q.rx_inv;
    assign loopbk_o     = q.loopbk;
    assign tx_rst_o     = q.tx_rst;
    assign rx_rst_o     = q.rx_rst;
    assign mult_o       = q.mult;
    assign ref_half_o   = q.ref_half;
    assign rx_term_o    = q.rx_term;
    assign ssp_en_o     = q.ssp;
    assign phy_rst_o    = q.phy_rst;
    assign pll_en_o     = q.pll_en;
    assign tx_cm_en_o   = q.cm_en;
    assign rxpll_en_o   = q.rxpll_en;
    assign tx_en_o      = q.tx_en;
    assign tx_data_en_o = q.txd_en;
    assign rx_data_en_o = q.rxd_en;
    assign busy_o       = !idle_like;
    assign done_o       = q.done;
    assign err_o        = q.err;
endmodule

// File: rtl/lane_seq_checker.sv
module lane_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       st_pll_i,
    input logic       st_cm_i,
    input logic       st_rxpll_i,
    input logic       st_tx_i,
    input logic       ssp_en_o,
    input logic       phy_rst_o,
    input logic       pll_en_o,
    input logic       tx_cm_en_o,
    input logic       rxpll_en_o,
    input logic       tx_en_o,
    input logic       tx_data_en_o,
    input logic       done_o,
    input logic [2:0] err_o
);
    assert_phy_after_ssp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst_o) |-> ssp_en_o);

    assert_pll_after_phy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en_o) |-> (!phy_rst_o && ssp_en_o));

    assert_cm_needs_pll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_cm_en_o) |-> ($past(st_pll_i) && pll_en_o));

    assert_txen_needs_cm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> ($past(st_cm_i) && rxpll_en_o && tx_cm_en_o));

    assert_data_needs_checks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_data_en_o) |-> ($past(st_rxpll_i) && $past(st_tx_i) && $past(tx_en_o)));

    assert_err_excl_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o != 3'd0) |-> !done_o);

    assert_err_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_o != 3'd0) && !start_i) |=> (err_o == $past(err_o)));
endmodule

bind lane_bringup_seq lane_seq_checker i_lane_seq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .st_pll_i     (st_pll_i),
    .st_cm_i      (st_cm_i),
    .st_rxpll_i   (st_rxpll_i),
    .st_tx_i      (st_tx_i),
    .ssp_en_o     (ssp_en_o),
    .phy_rst_o    (phy_rst_o),
    .pll_en_o     (pll_en_o),
    .tx_cm_en_o   (tx_cm_en_o),
    .rxpll_en_o   (rxpll_en_o),
    .tx_en_o      (tx_en_o),
    .tx_data_en_o (tx_data_en_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/test_lane_bringup_seq.sv
module test_lane_bringup_seq;
    localparam int MS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode = 1'b0, speed = 1'b0, txi = 1'b0, rxi = 1'b0, lpb = 1'b0;
    logic [1:0] strap = 2'd0;
    logic s_pll = 1'b1, s_cm = 1'b1, s_rxpll = 1'b1, s_tx = 1'b1;
    logic lane10b, tx_inv, rx_inv, loopbk, tx_rst, rx_rst, ref_half, rx_term;
    logic ssp, phy_rst, pll_en, cm_en, rxpll_en, tx_en, txd_en, rxd_en, busy, done;
    logic [1:0] tx_rate, rx_rate;
    logic [6:0] mult;
    logic [2:0] err;

    int tests = 0, fails = 0;
    int k_lane, k_mult, k_ssp, k_phy, k_pll, k_cm, k_rxtx, k_end;
    logic d_first;
    logic [2:0] e_first;

    always #2.5 clk = ~clk;

    lane_bringup_seq #(.MS_CYCLES(MS)) i_lane_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_sgmii_i(mode),
        .speed_2g5_i(speed), .ref_strap_i(strap), .tx_inv_i(txi), .rx_inv_i(rxi),
        .loopbk_i(lpb), .st_pll_i(s_pll), .st_cm_i(s_cm), .st_rxpll_i(s_rxpll),
        .st_tx_i(s_tx), .lane_10b_o(lane10b), .tx_rate_o(tx_rate), .rx_rate_o(rx_rate),
        .tx_inv_o(tx_inv), .rx_inv_o(rx_inv), .loopbk_o(loopbk), .tx_rst_o(tx_rst),
        .rx_rst_o(rx_rst), .mult_o(mult), .ref_half_o(ref_half), .rx_term_o(rx_term),
        .ssp_en_o(ssp), .phy_rst_o(phy_rst), .pll_en_o(pll_en), .tx_cm_en_o(cm_en),
        .rxpll_en_o(rxpll_en), .tx_en_o(tx_en), .tx_data_en_o(txd_en),
        .rx_data_en_o(rxd_en), .busy_o(busy), .done_o(done), .err_o(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected {lane10b, rate[1:0], mult[6:0], half}
    function automatic logic [10:0] exp_cfg(input logic m, input logic s, input logic [1:0] st);
        logic r125;
        int   mm;
        logic [1:0] rt;
        r125 = st[0] ^ st[1];
        mm   = r125 ? 40 : 100;
        rt   = 2'd0;
        if (m) begin
            rt = s ? 2'd1 : 2'd2;
            if (s) mm = mm * 5 / 4;
        end
        return {m, rt, 7'(mm), r125};
    endfunction

    task automatic run_seq(input bit pulse, input int inj);
        k_lane = -1; k_mult = -1; k_ssp = -1; k_phy = -1;
        k_pll = -1; k_cm = -1; k_rxtx = -1; k_end = -1;
        if (pulse) start = 1'b1;
        for (int k = 1; k <= 20 * MS + 20; k++) begin
            @(negedge clk);
            start = (k == inj);
            if (k == 1) begin d_first = done; e_first = err; end
            if (k_lane < 0 && !tx_rst && !rx_rst) k_lane = k;
            if (k_mult < 0 && mult != 7'd0) k_mult = k;
            if (k_ssp < 0 && ssp) k_ssp = k;
            if (k_phy < 0 && !phy_rst) k_phy = k;
            if (k_pll < 0 && pll_en) k_pll = k;
            if (k_cm < 0 && cm_en) k_cm = k;
            if (k_rxtx < 0 && tx_en && rxpll_en) k_rxtx = k;
            if (done || err != 3'd0) begin k_end = k; break; end
        end
        start = 1'b0;
    endtask

    task automatic check_cfg(input string req);
        logic [10:0] e;
        e = exp_cfg(mode, speed, strap);
        chk({lane10b, tx_rate, mult, ref_half} == e && rx_rate == tx_rate, req,
            {lane10b, tx_rate, mult, ref_half}, e);
        chk(tx_inv == txi && rx_inv == rxi && loopbk == lpb, req,
            {tx_inv, rx_inv, loopbk}, {txi, rxi, lpb});
    endtask

    initial begin
        #200000;
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tx_rst && rx_rst && phy_rst && !ssp && !pll_en && !cm_en && !tx_en && !rxpll_en
            && !txd_en && !rxd_en && !done && !busy && err == 0 && mult == 0 && !rx_term,
            "R1 reset", {tx_rst, rx_rst, phy_rst, done}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R6 R7 R9 directed timing, multiplexed mode, 125 MHz
        mode = 0; speed = 0; strap = 2'd1;
        run_seq(1, 0);
        chk(k_lane == 1, "R5 lane cfg edge", k_lane, 1);
        chk(k_mult == 2, "R5 mult edge", k_mult, 2);
        chk(k_ssp == 4 && !rx_term, "R5 ssp edge", k_ssp, 4);
        chk(k_phy == 4 + MS, "R6 phy reset release", k_phy, 4 + MS);
        chk(k_pll == 4 + 2 * MS, "R6 pll enable", k_pll, 4 + 2 * MS);
        chk(k_cm == 4 + 9 * MS, "R6 cm enable", k_cm, 4 + 9 * MS);
        chk(k_rxtx == 4 + 10 * MS, "R7 rx/tx enable", k_rxtx, 4 + 10 * MS);
        chk(k_end == 4 + 11 * MS && done && txd_en && rxd_en, "R9 done", k_end, 4 + 11 * MS);
        check_cfg("R3 quad 125");
        repeat (5) @(negedge clk);
        chk(done && txd_en && rxd_en, "R9 done held", done, 1);

        // R11 start while busy ignored
        run_seq(1, 6);
        chk(k_end == 4 + 11 * MS && done, "R11 busy start ignored", k_end, 4 + 11 * MS);

        // R12 speed change while done reruns
        mode = 1; run_seq(1, 0);
        @(negedge clk); speed = 1'b1;
        run_seq(0, 0);
        chk(d_first == 1'b0, "R12 done drops", d_first, 0);
        chk(k_end == 4 + 11 * MS && done, "R12 rerun done", k_end, 4 + 11 * MS);
        check_cfg("R12 new speed");

        // R8 failure points
        s_pll = 0; run_seq(1, 0);
        chk(err == 3'd1 && k_end == 4 + 9 * MS && !cm_en, "R8 pll fail", err, 1);
        s_pll = 1; s_cm = 0; run_seq(1, 0);
        chk(err == 3'd2 && k_end == 4 + 10 * MS && !tx_en, "R8 cm fail", err, 2);
        s_cm = 1; s_rxpll = 0; s_tx = 0; run_seq(1, 0);
        chk(err == 3'd3 && k_end == 4 + 11 * MS && !txd_en, "R8 rxpll before tx", err, 3);
        s_rxpll = 1; run_seq(1, 0);
        chk(err == 3'd4 && !done, "R8 tx fail", err, 4);
        // R10 error holds, then clears on start
        speed = 0;
        repeat (10) @(negedge clk);
        chk(err == 3'd4 && !busy, "R10 err held", err, 4);
        s_tx = 1; run_seq(1, 0);
        chk(e_first == 3'd0, "R10 err cleared", e_first, 0);
        chk(done, "R10 rerun passes", done, 1);

        // R2 R3 R4 random configurations
        void'($urandom(32'd4711));
        for (int i = 0; i < 40; i++) begin
            mode = 1'($urandom); speed = 1'($urandom); strap = 2'($urandom);
            txi = 1'($urandom); rxi = 1'($urandom); lpb = 1'($urandom);
            run_seq(1, 0);
            chk(k_end == 4 + 11 * MS && done, "R9 random run", k_end, 4 + 11 * MS);
            if (mode) check_cfg("R4 sgmii cfg");
            else      check_cfg("R3 quad cfg");
            chk(ref_half == (strap == 2'd1 || strap == 2'd2), "R2 ref strap", ref_half, strap);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule